// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt input lines into a vector of pending requests. Every line has its own trigger-mode bit. A line in level mode has a pending bit that follows the line. A line in edge mode latches a rising edge, and that request stays pending until it is acknowledged. The inputs are sampled on the clock. The previous sample of each line is kept in a history register, so an edge is a simple comparison between the new sample and the stored one.

Each cycle the block also reports, per line, three things:
- whether an asserted request set a pending bit that was clear (a new request);
- whether it landed on a bit that was already pending (a merged request);
- whether it arrived while the line's mask bit was set.

The trigger-mode register is written through a byte port and read back on a separate byte port. Writes pass through a fixed writable-bit mask. One parameter picks between the primary instance and the secondary instance, and that choice sets the mask. Priority resolution and in-service tracking live in a neighbouring block, which consumes the pending vector.

Top module: `irqLatch`

## Requirements
- R1: After reset the pending vector, the new, merged and masked report vectors and the trigger-mode readback are all zero.
- R2: A line whose trigger-mode bit is 1 (level mode) has its pending bit equal to the input sampled at the previous clock edge.
- R3: A line whose trigger-mode bit is 0 (edge mode) becomes pending one cycle after a sample of 1 follows a sample of 0. Later samples of 0 leave the pending bit set.
- R4: A request event is a sample of 1 in level mode, or a 0-to-1 transition in edge mode. For one cycle after the event, bit i of newReq is 1 if the pending bit was clear and bit i of mergedReq is 1 if the pending bit was already set.
- R5: For one cycle after a request event on line i, bit i of maskedReq is 1 if bit i of maskIn was 1 at the event.
- R6: A trigger-mode write stores tmWrData ANDed with the writable mask. The mask is 0xF8 when SECONDARY is 0 and 0xDE when SECONDARY is 1.
- R7: An acknowledge (ackValid with line index ackIdx) clears the pending bit of that line only in edge mode. A level-mode pending bit is not affected.
- R8: When an acknowledge and a new edge event hit the same edge-mode line in the same cycle, the line stays pending.
- R9: Without a write, the trigger-mode readback does not change. The mode used in a cycle is the value held before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 8 | Raw interrupt input levels |
| maskIn | input | 8 | Per-line mask bits, 1 = masked |
| ackValid | input | 1 | Acknowledge strobe |
| ackIdx | input | 3 | Line index being acknowledged |
| tmWrEn | input | 1 | Trigger-mode register write enable |
| tmWrData | input | 8 | Trigger-mode write data, 1 = level |
| tmRdData | output | 8 | Trigger-mode register readback |
| pendVec | output | 8 | Pending request vector |
| newReq | output | 8 | Request newly latched last cycle |
| mergedReq | output | 8 | Request merged into an existing pending bit |
| maskedReq | output | 8 | Request arrived on a masked line |

## Verification
The hardest case to reach is an edge-mode line where an acknowledge and a fresh rising edge land in the same cycle. This needs a pending request, a falling input and then a rising input timed exactly against the acknowledge strobe. A directed sequence builds that history on purpose before the random phase starts. In the random phase, slow-changing inputs and frequent acknowledges make the same collision happen many more times. Level-mode acknowledges and writes to the bits that the mask forces to zero are also forced directly on both instances.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  localparam int LINES = 8;

  typedef struct packed {
    logic [LINES-1:0] setPend;
    logic [LINES-1:0] clrPend;
    logic [LINES-1:0] newReq;
    logic [LINES-1:0] mergedReq;
    logic [LINES-1:0] maskedReq;
  } latchStrobes_t;

  // Writable trigger-mode bits for the two instance flavours
  function automatic logic [LINES-1:0] writableMask(input bit secondary);
    return secondary ? LINES'(8'hDE) : LINES'(8'hF8);
  endfunction

endpackage

// File: rtl/irqLatchCtrl.sv
module irqLatchCtrl
  import irq_latch_pkg::*;
#(
  parameter int NUM_LINES = LINES,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [NUM_LINES-1:0] maskIn,
  input  logic                 ackValid,
  input  logic [IDX_W-1:0]     ackIdx,
  input  logic [NUM_LINES-1:0] pendQ,
  input  logic [NUM_LINES-1:0] prevQ,
  input  logic [NUM_LINES-1:0] trigModeQ,
  output latchStrobes_t        strobes
);

  logic [NUM_LINES-1:0] reqEvent;
  logic [NUM_LINES-1:0] ackHit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    // level: any high sample; edge: high now and low last cycle
    assign reqEvent[i] = trigModeQ[i] ? lineIn[i] : (lineIn[i] & ~prevQ[i]);
    assign ackHit[i]   = ackValid && (ackIdx == IDX_W'(i)) && !trigModeQ[i];
  end

  always_comb begin
    strobes.setPend   = reqEvent;
    strobes.clrPend   = (trigModeQ & ~lineIn) | ackHit;
    strobes.newReq    = reqEvent & ~pendQ;
    strobes.mergedReq = reqEvent & pendQ;
    strobes.maskedReq = reqEvent & maskIn;
  end

endmodule

// File: rtl/irqLatchData.sv
module irqLatchData
  import irq_latch_pkg::*;
#(
  parameter int NUM_LINES = LINES,
  parameter bit SECONDARY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  latchStrobes_t        strobes,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 tmWrEn,
  input  logic [NUM_LINES-1:0] tmWrData,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] prevQ,
  output logic [NUM_LINES-1:0] trigModeQ,
  output logic [NUM_LINES-1:0] newReqQ,
  output logic [NUM_LINES-1:0] mergedReqQ,
  output logic [NUM_LINES-1:0] maskedReqQ
);

  localparam logic [NUM_LINES-1:0] WR_MASK = writableMask(SECONDARY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ      <= '0;
      prevQ      <= '0;
      trigModeQ  <= '0;
      newReqQ    <= '0;
      mergedReqQ <= '0;
      maskedReqQ <= '0;
    end else begin
      pendQ      <= (pendQ & ~strobes.clrPend) | strobes.setPend;
      prevQ      <= lineIn;
      newReqQ    <= strobes.newReq;
      mergedReqQ <= strobes.mergedReq;
      maskedReqQ <= strobes.maskedReq;
      if (tmWrEn) trigModeQ <= tmWrData & WR_MASK;
    end
  end

  assert_tm_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tmWrEn |=> $stable(trigModeQ));

  assert_tm_fixed_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    tmWrEn |=> ((trigModeQ | WR_MASK) == WR_MASK));

  assert_new_sets_pend_R4: assert property (@(posedge clk) disable iff (!rstN)
    (newReqQ & ~pendQ) == '0);

endmodule

// File: rtl/irqLatch.sv
module irqLatch
  import irq_latch_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  input  logic [LINES-1:0] maskIn,
  input  logic             ackValid,
  input  logic [2:0]       ackIdx,
  input  logic             tmWrEn,
  input  logic [LINES-1:0] tmWrData,
  output logic [LINES-1:0] tmRdData,
  output logic [LINES-1:0] pendVec,
  output logic [LINES-1:0] newReq,
  output logic [LINES-1:0] mergedReq,
  output logic [LINES-1:0] maskedReq
);

  latchStrobes_t strobes;
  logic [LINES-1:0] pendQ, prevQ, trigModeQ;

  irqLatchCtrl #(.NUM_LINES(LINES)) u_ctrl (
    .lineIn(lineIn), .maskIn(maskIn), .ackValid(ackValid), .ackIdx(ackIdx),
    .pendQ(pendQ), .prevQ(prevQ), .trigModeQ(trigModeQ), .strobes(strobes)
  );

  irqLatchData #(.NUM_LINES(LINES), .SECONDARY(SECONDARY)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lineIn(lineIn),
    .tmWrEn(tmWrEn), .tmWrData(tmWrData), .pendQ(pendQ), .prevQ(prevQ),
    .trigModeQ(trigModeQ), .newReqQ(newReq), .mergedReqQ(mergedReq),
    .maskedReqQ(maskedReq)
  );

  assign pendVec  = pendQ;
  assign tmRdData = trigModeQ;

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
      trigModeQ[i] |=> (pendQ[i] == $past(lineIn[i])));

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!trigModeQ[i] && pendQ[i] && !(ackValid && ackIdx == 3'(i))) |=> pendQ[i]);

    assert_edge_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!trigModeQ[i] && lineIn[i] && !prevQ[i]) |=> pendQ[i]);

    assert_ack_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
      (ackValid && ackIdx == 3'(i) && !trigModeQ[i] && !(lineIn[i] && !prevQ[i]))
        |=> !pendQ[i]);

    assert_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
      (lineIn[i] && !maskIn[i]) |=> !maskedReq[i]);
  end

endmodule

// File: tb/irqLatch_tb.sv
module irqLatch_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] lineIn = '0, maskIn = '0, tmWrData = '0;
  logic       ackValid = 1'b0, tmWrEn = 1'b0;
  logic [2:0] ackIdx = '0;
  logic [7:0] tmRd0, pend0, new0, merged0, masked0;
  logic [7:0] tmRd1, pend1, new1, merged1, masked1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqLatch #(.SECONDARY(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .maskIn(maskIn), .ackValid(ackValid),
    .ackIdx(ackIdx), .tmWrEn(tmWrEn), .tmWrData(tmWrData), .tmRdData(tmRd0),
    .pendVec(pend0), .newReq(new0), .mergedReq(merged0), .maskedReq(masked0)
  );

  irqLatch #(.SECONDARY(1'b1)) u_dutSec (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .maskIn(maskIn), .ackValid(ackValid),
    .ackIdx(ackIdx), .tmWrEn(tmWrEn), .tmWrData(tmWrData), .tmRdData(tmRd1),
    .pendVec(pend1), .newReq(new1), .mergedReq(merged1), .maskedReq(masked1)
  );

  // bench model state, index 0 = primary, 1 = secondary
  logic [7:0] mPend[2], mTm[2], mNew[2], mMerged[2], mMasked[2];
  logic [7:0] mPrev;
  string pendTag;

  function automatic logic [7:0] wmask(input int k);
    return (k == 0) ? 8'hF8 : 8'hDE;
  endfunction

  function automatic logic [7:0] events(input logic [7:0] tm, input logic [7:0] prev,
                                        input logic [7:0] inp);
    return (tm & inp) | (~tm & inp & ~prev);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Apply one cycle of stimulus, advance the model, compare after the edge
  task automatic step(input logic [7:0] inp, input logic [7:0] msk, input logic av,
                      input logic [2:0] ai, input logic wr, input logic [7:0] wd);
    logic [7:0] evt, ackBit;
    lineIn = inp; maskIn = msk; ackValid = av; ackIdx = ai; tmWrEn = wr; tmWrData = wd;
    pendTag = "R3";
    for (int k = 0; k < 2; k++) begin
      evt = events(mTm[k], mPrev, inp);
      ackBit = (av ? (8'h01 << ai) : 8'h00) & ~mTm[k];
      if (k == 0 && av) pendTag = ((evt & ackBit) != 0) ? "R8" : "R7";
      mNew[k]    = evt & ~mPend[k];
      mMerged[k] = evt & mPend[k];
      mMasked[k] = evt & msk;
      mPend[k]   = (mTm[k] & inp) | (~mTm[k] & ((mPend[k] & ~ackBit) | evt));
      if (wr) mTm[k] = wd & wmask(k);
    end
    mPrev = inp;
    @(negedge clk);
    chk({pendTag, " edge pend"}, pend0 & ~mTm[0], mPend[0] & ~mTm[0]);
    chk("R2 level pend", pend0 & mTm[0], mPend[0] & mTm[0]);
    chk("R4 newReq", new0, mNew[0]);
    chk("R4 mergedReq", merged0, mMerged[0]);
    chk("R5 maskedReq", masked0, mMasked[0]);
    chk(wr ? "R6 tm write" : "R9 tm hold", tmRd0, mTm[0]);
    chk(wr ? "R6 tm write sec" : "R9 tm hold sec", tmRd1, mTm[1]);
    chk("R7 pend sec", pend1, mPend[1]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 2; k++) begin
      mPend[k] = '0; mTm[k] = '0; mNew[k] = '0; mMerged[k] = '0; mMasked[k] = '0;
    end
    mPrev = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, before any stimulus
    chk("R1 pend", pend0, 8'h00);
    chk("R1 newReq", new0, 8'h00);
    chk("R1 mergedReq", merged0, 8'h00);
    chk("R1 maskedReq", masked0, 8'h00);
    chk("R1 tm", tmRd0, 8'h00);

    // R6: writable mask on both flavours
    step(8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 8'hFF);
    chk("R6 primary mask", tmRd0, 8'hF8);
    chk("R6 secondary mask", tmRd1, 8'hDE);
    step(8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 8'hF0); // lines 4..7 level, 0..3 edge

    // R3: edge on line 0 latches and survives the input falling
    step(8'h01, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00);
    step(8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R3 edge held", pend0[0], 1'b1);
    // R4: a second rise merges
    step(8'h01, 8'h01, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R4 merged", merged0[0], 1'b1);
    chk("R5 masked", masked0[0], 1'b1);
    // R8: fall, then acknowledge together with a new rise
    step(8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00);
    step(8'h01, 8'h00, 1'b1, 3'd0, 1'b0, 8'h00);
    chk("R8 ack with edge", pend0[0], 1'b1);
    // R7: plain acknowledge clears the edge line
    step(8'h01, 8'h00, 1'b1, 3'd0, 1'b0, 8'h00);
    chk("R7 edge ack clears", pend0[0], 1'b0);
    // R7: level line 4 is not cleared by ack
    step(8'h10, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00);
    step(8'h10, 8'h00, 1'b1, 3'd4, 1'b0, 8'h00);
    chk("R7 level ack ignored", pend0[4], 1'b1);
    // R2: level line clears when input falls
    step(8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00);
    chk("R2 level clears", pend0[4], 1'b0);

    // random phase with slow-changing inputs
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] inp, flip;
      flip = 8'($urandom) & 8'($urandom);
      inp = lineIn ^ flip;
      step(inp, 8'($urandom), ($urandom % 3) == 0, 3'($urandom),
           ($urandom % 40) == 0, 8'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule